// File: doc/BRIEF.md
# Transport Stream Packet Alignment Finder

This block takes a transport stream one byte per clock, qualified by a valid strobe, and works out where packets really begin. The marker byte 0x47 can also show up inside payload, so a single sighting proves nothing. The block keeps a small set of alignment candidates. Each candidate starts at a marker byte and checks whether another marker arrives exactly one packet length later. A candidate that fails is dropped. Once one candidate has collected the programmed run of correctly spaced markers, the block declares alignment.

Nothing is passed downstream while the search is going on. The byte that completes the search is forwarded with a packet-start pulse. From then on every valid input byte is forwarded, and a packet-start pulse marks each marker byte that falls on the locked phase. A clear pulse drops the alignment and restarts the search. Loss-of-lock detection and everything after alignment, such as buffering or filtering, belong to other blocks.

Top module: `tsync_acq`

## Requirements
- R1: A candidate only counts a marker (byte value 0x47) that arrives exactly 188 valid bytes after its previous marker. A 0x47 at any other spacing never adds to the count.
- R2: After asynchronous reset, `locked_o`, `dvalid_o` and `pkt_start_o` are low.
- R3: Outputs are registered. A byte accepted at a clock edge appears on `data_o`/`dvalid_o` just after that edge, and not earlier.
- R4: Three candidates exist. A 0x47 that continues no candidate opens the lowest-numbered free candidate, and that candidate's count starts at 1.
- R5: When a candidate has counted 187 bytes after its marker, the next valid byte decides its fate. A 0x47 raises its count by one and restarts its byte count. Any other value frees the candidate and sets its count to zero.
- R6: Lock is declared on the byte that brings any candidate's count to `need_cnt_i` (1 to 15). With `need_cnt_i` = 0, the first accepted marker locks. `locked_o` then stays high until a clear.
- R7: A 0x47 that arrives while all three candidates are busy, and none is due for its marker, is ignored. It opens nothing, and lock then comes one packet later than it otherwise would.
- R8: Before lock, `dvalid_o` stays low. The locking byte and every later valid byte are forwarded unchanged, with `dvalid_o` high.
- R9: After lock, `pkt_start_o` pulses for one cycle with each 0x47 that lies a whole number of packets (188 valid bytes) after the locking byte. A 0x47 at any other position gives no pulse.
- R10: A cycle with `bvalid_i` low advances nothing, and it produces neither `dvalid_o` nor `pkt_start_o` on the next cycle.
- R11: `clr_i` frees all candidates and drops lock, and it takes priority over a byte that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous restart of the search |
| need_cnt_i | input | 4 | Run of spaced markers required for lock |
| byte_i | input | 8 | Stream byte |
| bvalid_i | input | 1 | Stream byte qualifier |
| data_o | output | 8 | Forwarded byte |
| dvalid_o | output | 1 | Forwarded byte qualifier, low until lock |
| pkt_start_o | output | 1 | One-cycle pulse on a packet's first byte |
| locked_o | output | 1 | Alignment found |

## Verification
The assertions check several things on every cycle. Forwarded data never appears unlocked, and a start pulse always comes with a valid 0x47. Idle input cycles stay quiet, and lock stays set until a clear. A candidate's byte count never passes its limit, and at most one candidate opens per byte. At a due position, a candidate's count either rises or is dropped, as the byte decides. A marker arriving when every candidate is busy leaves the candidate set unchanged. Some behaviour can only be shown by the bench's streams: the exact byte on which lock lands with planted false markers before and after the real phase, the one-packet delay when every candidate is taken, the zero and maximum run settings, and the period of the start pulses.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam logic [7:0] TS_MARKER  = 8'h47;
  localparam int         TS_PKT_LEN = 188;
  localparam int         TS_CANDS   = 3;
  localparam int         TS_RUN_W   = 4;
endpackage

// File: rtl/tsync_alloc.sv
module tsync_alloc #(
  parameter int NUM = 3
) (
  input  logic [NUM-1:0] free_i,
  input  logic           req_i,
  output logic [NUM-1:0] grant_o
);
  logic [NUM:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM; i++) begin : g_pick
    assign grant_o[i]  = req_i & free_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | free_i[i];
  end

  always_comb begin
    p_one_grant_r4 : assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/tsync_cand.sv
module tsync_cand #(
  parameter int PKT_LEN = 188,
  parameter int RUN_W   = 4,
  localparam int DCW    = $clog2(PKT_LEN),
  localparam logic [DCW-1:0] LAST = DCW'(PKT_LEN - 1),
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             marker_i,
  input  logic             open_i,
  output logic             busy_o,
  output logic             cont_o,
  output logic [RUN_W-1:0] run_o
);
  logic             act_q, act_n;
  logic [DCW-1:0]   dcnt_q, dcnt_n;
  logic [RUN_W-1:0] run_q, run_n;
  logic             due;

  assign due    = act_q & (dcnt_q == LAST);
  assign busy_o = act_q;
  assign cont_o = due & marker_i;
  assign run_o  = run_q;

  always_comb begin
    act_n  = act_q;
    dcnt_n = dcnt_q;
    run_n  = run_q;
    if (clr_i) begin
      act_n  = 1'b0;
      dcnt_n = '0;
      run_n  = '0;
    end else if (step_i) begin
      if (act_q) begin
        if (due) begin
          if (marker_i) begin
            dcnt_n = '0;
            run_n  = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
          end else begin
            act_n  = 1'b0;
            dcnt_n = '0;
            run_n  = '0;
          end
        end else begin
          dcnt_n = dcnt_q + 1'b1;
        end
      end else if (open_i) begin
        act_n  = 1'b1;
        dcnt_n = '0;
        run_n  = RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dcnt_q <= '0;
      run_q  <= '0;
    end else begin
      act_q  <= act_n;
      dcnt_q <= dcnt_n;
      run_q  <= run_n;
    end
  end

  p_dcnt_bound_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= LAST);

  p_drop_on_miss_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (due && step_i && !marker_i && !clr_i) |=> (!act_q && run_q == '0));

  p_count_on_hit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (due && step_i && marker_i && !clr_i) |=>
      (act_q && dcnt_q == '0 &&
       run_q == (($past(run_q) == RUN_MAX) ? RUN_MAX : $past(run_q) + 1'b1)));
endmodule

// File: rtl/tsync_acq.sv
module tsync_acq
  import tsync_pkg::*;
#(
  parameter logic [7:0] MARKER  = TS_MARKER,
  parameter int         PKT_LEN = TS_PKT_LEN,
  parameter int         NCAND   = TS_CANDS,
  parameter int         RUN_W   = TS_RUN_W,
  localparam int        DCW     = $clog2(PKT_LEN),
  localparam logic [DCW-1:0] LAST = DCW'(PKT_LEN - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [RUN_W-1:0] need_cnt_i,
  input  logic [7:0]       byte_i,
  input  logic             bvalid_i,
  output logic [7:0]       data_o,
  output logic             dvalid_o,
  output logic             pkt_start_o,
  output logic             locked_o
);
  logic             locked_q, locked_n;
  logic [DCW-1:0]   pos_q, pos_n;
  logic [7:0]       data_q, data_n;
  logic             dv_q, dv_n;
  logic             st_q, st_n;

  logic             is_marker, step, any_cont, any_open, accepted, lock_now;
  logic [NCAND-1:0] busy, cont, grant, hit;

  assign is_marker = (byte_i == MARKER);
  assign step      = bvalid_i & ~locked_q;

  for (genvar i = 0; i < NCAND; i++) begin : g_cand
    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   run_inc;

    tsync_cand #(.PKT_LEN(PKT_LEN), .RUN_W(RUN_W)) u_cand (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr_i),
      .step_i   (step),
      .marker_i (is_marker),
      .open_i   (grant[i]),
      .busy_o   (busy[i]),
      .cont_o   (cont[i]),
      .run_o    (run)
    );

    assign run_inc = {1'b0, run} + {{RUN_W{1'b0}}, 1'b1};
    assign hit[i]  = cont[i] & (run_inc == {1'b0, need_cnt_i});
  end

  assign any_cont = |cont;

  tsync_alloc #(.NUM(NCAND)) u_alloc (
    .free_i  (~busy),
    .req_i   (step & is_marker & ~any_cont),
    .grant_o (grant)
  );

  assign any_open = |grant;
  assign accepted = any_cont | any_open;
  assign lock_now = step & ~clr_i &
                    ((accepted & (need_cnt_i == '0)) |
                     (|hit) |
                     (any_open & (need_cnt_i == RUN_W'(1))));

  always_comb begin
    locked_n = locked_q;
    pos_n    = pos_q;
    data_n   = data_q;
    dv_n     = 1'b0;
    st_n     = 1'b0;
    if (bvalid_i) data_n = byte_i;
    if (clr_i) begin
      locked_n = 1'b0;
      pos_n    = '0;
    end else if (lock_now) begin
      locked_n = 1'b1;
      pos_n    = (LAST == '0) ? '0 : DCW'(1);
      dv_n     = 1'b1;
      st_n     = 1'b1;
    end else if (locked_q && bvalid_i) begin
      pos_n = (pos_q == LAST) ? '0 : pos_q + 1'b1;
      dv_n  = 1'b1;
      st_n  = is_marker & (pos_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
      dv_q     <= 1'b0;
      st_q     <= 1'b0;
    end else begin
      locked_q <= locked_n;
      pos_q    <= pos_n;
      dv_q     <= dv_n;
      st_q     <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (bvalid_i) data_q <= data_n;
  end

  assign data_o      = data_q;
  assign dvalid_o    = dv_q;
  assign pkt_start_o = st_q;
  assign locked_o    = locked_q;

  p_no_data_unlocked_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> locked_o);

  p_start_is_marker_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start_o |-> (dvalid_o && data_o == MARKER));

  p_lock_holds_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !clr_i) |=> locked_o);

  p_idle_quiet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bvalid_i |=> (!dvalid_o && !pkt_start_o));

  p_clear_wins_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!locked_o && !dvalid_o));

  p_full_ignore_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_marker && (&busy) && !any_cont && !clr_i) |=>
      ($stable(busy) && !locked_o));
endmodule

// File: tb/tsync_acq_test.sv
module tsync_acq_test;
  typedef struct packed {
    int req;
    int off;
    int f0;
    int f1;
    int f2;
    int gap;
    int exp;
  } vec_t;

  localparam int PL = 188;
  localparam int NV = 8;
  // req, real phase, false markers (-1 none), idle gaps, expected lock byte
  localparam vec_t VEC [NV] = '{
    '{3,  10, -1, -1, -1, 1,  386},  // R4 R6 R10 clean stream with gaps
    '{3,  50,  5, 20, -1, 0,  426},  // R4 R5 two false markers first
    '{4,  60,  5, 20, 30, 0,  812},  // R7 all candidates busy at first real marker
    '{0,   7, -1, -1, -1, 0,    7},  // R6 zero run locks at first marker
    '{1, 100, 150, -1, -1, 0, 100},  // R6 R9 run of one, false marker after lock
    '{15,  0, -1, -1, -1, 0, 2632},  // R6 maximum run
    '{2,  30, 40, -1, -1, 1,  218},  // R1 R5 false marker in payload, gaps
    '{2,   0, 500, -1, -1, 0, 188}   // R9 false marker well after lock
  };

  logic       clk = 1'b0;
  logic       rst_n, clr, bv;
  logic [3:0] need;
  logic [7:0] bt;
  logic [7:0] data_o;
  logic       dvalid_o, pkt_start_o, locked_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tsync_acq uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .need_cnt_i(need),
    .byte_i(bt), .bvalid_i(bv), .data_o(data_o), .dvalid_o(dvalid_o),
    .pkt_start_o(pkt_start_o), .locked_o(locked_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input vec_t v, input int k);
    if (k >= v.off && ((k - v.off) % PL) == 0) return 8'h47;
    if (k == v.f0 || k == v.f1 || k == v.f2) return 8'h47;
    return 8'(k % 64);
  endfunction

  task automatic put(input logic v, input logic [7:0] b, input logic c);
    @(negedge clk);
    bv  = v;
    bt  = b;
    clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VEC[idx];
    int first_dv = -1;
    int state_bad = 0, data_bad = 0, start_bad = 0, quiet_bad = 0;
    int last = v.exp + 2 * PL + 5;
    need = 4'(v.req);
    put(1'b0, 8'h00, 1'b1);
    for (int k = 0; k <= last; k++) begin
      logic [7:0] b = gen(v, k);
      bit exp_on, exp_st;
      put(1'b1, b, 1'b0);
      exp_on = (k >= v.exp);
      exp_st = exp_on && (((k - v.exp) % PL) == 0);
      if (dvalid_o && first_dv < 0) first_dv = k;
      if (dvalid_o != exp_on || locked_o != exp_on) state_bad++;
      if (dvalid_o && data_o != b) data_bad++;
      if (pkt_start_o != exp_st) start_bad++;
      if (v.gap != 0 && (k % 5) == 0) begin
        put(1'b0, 8'h47, 1'b0);
        if (dvalid_o || pkt_start_o) quiet_bad++;
      end
    end
    chk(first_dv == v.exp, "R6 R1 R4 R5 R7", $sformatf("lock byte, vector %0d", idx),
        first_dv, v.exp);
    chk(state_bad == 0, "R8", $sformatf("valid/lock gating, vector %0d", idx), state_bad, 0);
    chk(data_bad == 0, "R8", $sformatf("forwarded data, vector %0d", idx), data_bad, 0);
    chk(start_bad == 0, "R9", $sformatf("start pulses, vector %0d", idx), start_bad, 0);
    if (v.gap != 0)
      chk(quiet_bad == 0, "R10", $sformatf("idle cycles, vector %0d", idx), quiet_bad, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr   = 1'b0;
    bv    = 1'b0;
    bt    = 8'h00;
    need  = 4'd3;
    #23;
    chk(!locked_o && !dvalid_o && !pkt_start_o, "R2", "reset outputs",
        {locked_o, dvalid_o, pkt_start_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    put(1'b1, 8'h47, 1'b0);
    chk(!locked_o && !dvalid_o, "R2", "one marker after reset, run 3",
        {locked_o, dvalid_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R3: block is locked from the last vector; output follows one edge later
    @(negedge clk);
    bv = 1'b1; bt = 8'h3c; clr = 1'b0;
    #1;
    chk(data_o != 8'h3c, "R3", "data before edge", data_o, 0);
    @(posedge clk);
    #1;
    chk(data_o == 8'h3c && dvalid_o, "R3", "data after edge", data_o, 8'h3c);

    // R11: clear with a marker in the same cycle; marker must not count
    need = 4'd1;
    put(1'b1, 8'h47, 1'b1);
    chk(!locked_o && !dvalid_o, "R11", "clear drops lock", {locked_o, dvalid_o}, 0);
    put(1'b1, 8'h05, 1'b0);
    chk(!locked_o && !dvalid_o, "R11", "marker with clear ignored", locked_o, 0);
    put(1'b1, 8'h47, 1'b0);
    chk(locked_o && dvalid_o && pkt_start_o, "R11 R6", "relock after clear",
        {locked_o, dvalid_o, pkt_start_o}, 7);

    // R10: idle cycle while locked
    put(1'b0, 8'h47, 1'b0);
    chk(!dvalid_o && !pkt_start_o && locked_o, "R10", "idle while locked",
        {dvalid_o, pkt_start_o}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule